// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

At power-up this block reads a list of configuration entries from a serial EEPROM with a three-wire-plus-select interface (chip select, serial clock, data to the memory, data from the memory). Each entry is two consecutive 16-bit words: the first names a register offset and the second carries the value. For every entry the block emits a one-cycle write strobe with offset and data. A reserved offset word of 0xFFFF ends the list.

The same sequence times a reset pulse for an external PHY. Every entry, and the end marker as well, occupies one fixed slot of `SLOT_CYCLES` clocks. The reset output goes active at the first slot boundary after the entry that sets the polarity bit. It returns to idle when the end-marker slot closes. To make the pulse longer, add entries; writes to the padding offset 0x28 exist only for this purpose. A power-good input forces the reset output idle whenever it is low. After loading completes, three host control bits drive the EEPROM pins directly for software bit-banging, and the memory's data output is returned to the host.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Each read is framed by chip select high. The bits sent are start bit 1, opcode bits 1 then 0, and then the `ADDR_W`-bit word address MSB first. The block then clocks in 16 data bits MSB first. The serial clock period is 2*`CLK_DIV` system clocks. Data is taken at the end of each high phase, and the serial clock is high only while chip select is high.
- R2: Words are read from address 0 upward with no gaps. An offset word is followed by its data word. An offset word equal to 0xFFFF ends the sequence and is not followed by a data word.
- R3: Each entry whose offset (low 8 bits of the offset word) is not 0x28 produces exactly one single-cycle `reg_we`. The pulse carries that offset on `reg_ofs` and the data word on `reg_data`, and entries appear in EEPROM order.
- R4: An entry with offset 0x28 produces no write strobe but still consumes a full slot.
- R5: An entry with offset `CMD_OFS` (default 0x0C) sets the reset polarity from bit 0 of its data word: 1 means active-high, 0 means active-low. Before any such entry the polarity is 0.
- R6: Slots are `SLOT_CYCLES` clocks long and counted from reset release. If K entries follow the polarity entry, the reset output is active for exactly (K+1)*`SLOT_CYCLES` clocks, and `done` rises (entries+1)*`SLOT_CYCLES` clocks after reset release.
- R7: While `pg` is low, `phy_rst` is held at the idle level (the inverse of the polarity).
- R8: Chip select stays low for at least one serial clock period (2*`CLK_DIV` clocks) between reads.
- R9: `done` rises on the same clock as the reset output returns to idle, and it stays high until reset.
- R10: Once `done` is high, `host_ctrl[2]`, `host_ctrl[1]` and `host_ctrl[0]` drive chip select, serial clock and data-to-memory. `host_do` always reflects `ee_do`.
- R11: While loading, `host_ctrl` has no effect on the EEPROM pins or on the loaded values.
- R12: During reset, `done`, `reg_we`, `ee_cs` and `ee_sk` are 0 and `phy_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg | input | 1 | Power good; low blocks the PHY reset |
| host_ctrl | input | 3 | Host bit-bang bits: [2] select, [1] clock, [0] data |
| host_do | output | 1 | EEPROM data output returned to host |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Data into the EEPROM |
| ee_do | input | 1 | Data out of the EEPROM |
| reg_we | output | 1 | Register write strobe |
| reg_ofs | output | 8 | Register offset |
| reg_data | output | 16 | Register data |
| phy_rst | output | 1 | PHY reset, polarity programmable |
| done | output | 1 | Load complete |

## Verification
Everything is timed from reset release. `done` comes exactly (entries+1)*`SLOT_CYCLES` clocks later, and the reset pulse lasts (K+1)*`SLOT_CYCLES` clocks. Reset is released 1 ns after a rising edge and every output is sampled on the falling edge, so the bench counts whole cycles between register updates and can compare those counts exactly. Write strobes are compared in order against a queue filled from the EEPROM image as they appear, whatever their timing. The EEPROM model checks each read's framing and address on the serial clock edges it sees.

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int CLK_DIV = 25,
  parameter int ADDR_W = 6,
  parameter int SLOT_CYCLES = 12000,
  parameter logic [7:0] CMD_OFS = 8'h0C,
  parameter logic [7:0] PAD_OFS = 8'h28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pg,
  input  logic [2:0]  host_ctrl,
  output logic        host_do,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic        reg_we,
  output logic [7:0]  reg_ofs,
  output logic [15:0] reg_data,
  output logic        phy_rst,
  output logic        done
);
  localparam int FW = 3 + ADDR_W;
  localparam int NB = FW + 16;
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int BW = $clog2(NB + 1);
  localparam int SW = $clog2(SLOT_CYCLES + 1);

  typedef enum logic [2:0] {GAP, LO, HI, SLOT, FIN} st_t;
  st_t st;

  logic [DW-1:0] dc;
  logic [BW-1:0] bn;
  logic [SW-1:0] sc;
  logic [ADDR_W-1:0] ea;
  logic [15:0] sh;
  logic [7:0] ofs_q;
  logic gap2, phase, fin_pend, pol, pol_seen, rst_act, cs_q, sk_q;

  wire tick     = (dc == DW'(CLK_DIV - 1));
  wire slot_end = (sc == SW'(SLOT_CYCLES - 1));
  wire [FW-1:0] frame = {3'b110, ea};
  wire [FW-1:0] fsh = frame << bn;
  wire [15:0] word = {sh[14:0], ee_do};
  wire busy = (st != FIN);

  assign ee_cs   = busy ? cs_q : host_ctrl[2];
  assign ee_sk   = busy ? sk_q : host_ctrl[1];
  assign ee_di   = busy ? (cs_q & fsh[FW-1]) : host_ctrl[0];
  assign host_do = ee_do;
  assign phy_rst = (rst_act & pg) ? pol : ~pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= GAP; dc <= '0; bn <= '0; sc <= '0; ea <= '0; sh <= '0; ofs_q <= '0;
      gap2 <= 1'b0; phase <= 1'b0; fin_pend <= 1'b0; pol <= 1'b0; pol_seen <= 1'b0;
      rst_act <= 1'b0; cs_q <= 1'b0; sk_q <= 1'b0; done <= 1'b0;
      reg_we <= 1'b0; reg_ofs <= '0; reg_data <= '0;
    end else begin
      reg_we <= 1'b0;
      sc <= slot_end ? '0 : sc + 1'b1;
      dc <= (tick || st == SLOT || st == FIN) ? '0 : dc + 1'b1;
      case (st)
        GAP: if (tick) begin
          gap2 <= ~gap2;
          if (gap2) begin
            gap2 <= 1'b0; cs_q <= 1'b1; bn <= '0; st <= LO;
          end
        end
        LO: if (tick) begin
          sk_q <= 1'b1; st <= HI;
        end
        HI: if (tick) begin
          sk_q <= 1'b0;
          sh <= word;
          if (bn == BW'(NB - 1)) begin
            cs_q <= 1'b0;
            ea <= ea + 1'b1;
            if (!phase) begin
              if (word == 16'hFFFF) begin
                fin_pend <= 1'b1; st <= SLOT;
              end else begin
                ofs_q <= word[7:0]; phase <= 1'b1; st <= GAP;
              end
            end else begin
              phase <= 1'b0; st <= SLOT;
              if (ofs_q != PAD_OFS) begin
                reg_we <= 1'b1; reg_ofs <= ofs_q; reg_data <= word;
              end
              if (ofs_q == CMD_OFS) begin
                pol <= word[0]; pol_seen <= 1'b1;
              end
            end
          end else begin
            bn <= bn + 1'b1; st <= LO;
          end
        end
        SLOT: if (slot_end) begin
          if (fin_pend) begin
            rst_act <= 1'b0; done <= 1'b1; st <= FIN;
          end else begin
            rst_act <= rst_act | pol_seen; st <= GAP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
module eeprom_cfg_loader_chk #(
  parameter logic [7:0] PAD_OFS = 8'h28
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pg,
  input logic       pol,
  input logic       phy_rst,
  input logic       done,
  input logic       reg_we,
  input logic [7:0] reg_ofs,
  input logic       ee_cs,
  input logic       ee_sk
);
  // R4
  no_pad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_ofs != PAD_OFS);
  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R7
  pg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg |-> phy_rst == ~pol);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> phy_rst == ~pol);
  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $fell(ee_cs)) |=> !ee_cs);
  // R1
  sk_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && ee_sk) |-> ee_cs);
endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk #(.PAD_OFS(PAD_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg(pg), .pol(pol), .phy_rst(phy_rst), .done(done),
  .reg_we(reg_we), .reg_ofs(reg_ofs), .ee_cs(ee_cs), .ee_sk(ee_sk)
);

// File: tb/tb_eeprom_cfg_loader.sv
`timescale 1ns/1ps
module tb_eeprom_cfg_loader;
  localparam int CLK_DIV = 2;
  localparam int ADDR_W = 6;
  localparam int SLOT = 256;
  localparam logic [7:0] CMD = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0, pg = 1'b1;
  logic [2:0] host_ctrl = 3'b000;
  logic host_do, ee_cs, ee_sk, ee_di, ee_do, reg_we, phy_rst, done;
  logic [7:0] reg_ofs;
  logic [15:0] reg_data;

  always #10 clk = ~clk;

  eeprom_cfg_loader #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .SLOT_CYCLES(SLOT), .CMD_OFS(CMD)) dut (
    .clk(clk), .rst_n(rst_n), .pg(pg), .host_ctrl(host_ctrl), .host_do(host_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .reg_we(reg_we), .reg_ofs(reg_ofs), .reg_data(reg_data), .phy_rst(phy_rst), .done(done));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // EEPROM model
  logic [15:0] mem [64];
  logic [8:0] cmd = '0;
  logic [5:0] maddr = '0;
  int mcnt = 0, mk = 0, exp_ea = 0;
  bit msend = 0, model_chk = 1;
  logic model_do = 1'b0, ovr_en = 1'b0, ovr_val = 1'b0;
  assign ee_do = ovr_en ? ovr_val : model_do;

  always @(posedge ee_sk or negedge ee_sk or negedge ee_cs or negedge rst_n) begin
    if (!rst_n) begin
      exp_ea = 0; mcnt = 0; mk = 0; msend = 0; model_do = 1'b0;
    end else if (!ee_cs) begin
      mcnt = 0; mk = 0; msend = 0; model_do = 1'b0;
    end else if (ee_sk) begin
      cmd = {cmd[7:0], ee_di};
      mcnt++;
      if (mcnt == 9) begin
        msend = 1; maddr = cmd[5:0];
        if (model_chk) begin
          chk(cmd[8:6] == 3'b110, "R1", "start+opcode", cmd[8:6], 3'b110);
          chk(maddr == exp_ea[5:0], "R2", "read address", maddr, exp_ea[5:0]);
          exp_ea++;
        end
      end
    end else if (msend) begin
      model_do = (mk < 16) ? mem[maddr][15-mk] : 1'b0;
      mk++;
    end
  end

  // scoreboard and monitor
  logic [23:0] expq[$];
  int wp = 0;
  logic act_lvl = 1'b0;
  bit polw = 0;
  int pcnt = 0, dcnt = 0, pglow = 0, pgbad = 0, lowrun = 0, sb_err = 0;
  bit seenhi = 0;

  task automatic add_entry(input logic [7:0] o, input logic [15:0] d);
    mem[wp] = {8'h00, o}; mem[wp+1] = d; wp += 2;
    if (o != 8'h28) expq.push_back({o, d});
  endtask

  task automatic new_image();
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    wp = 0;
    expq.delete();
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      polw = 0; pcnt = 0; dcnt = 0; pglow = 0; pgbad = 0; lowrun = 0; seenhi = 0;
    end else begin
      if (reg_we) begin
        if (expq.size() == 0) begin
          sb_err++;
          chk(0, "R3", "unexpected write", {reg_ofs, reg_data}, 0);
        end else begin
          logic [23:0] e;
          e = expq.pop_front();
          if ({reg_ofs, reg_data} != e) sb_err++;
          chk({reg_ofs, reg_data} == e, "R3", "write", {reg_ofs, reg_data}, e);
        end
        if (reg_ofs == CMD) polw = 1;
      end
      if (!done) begin
        dcnt++;
        if (polw && phy_rst == act_lvl) pcnt++;
        if (polw && !pg) begin
          pglow++;
          if (phy_rst == act_lvl) pgbad++;
        end
        if (!ee_cs) lowrun++;
        else begin
          if (seenhi && lowrun > 0) chk(lowrun >= 2*CLK_DIV, "R8", "cs low gap", lowrun, 2*CLK_DIV);
          lowrun = 0; seenhi = 1;
        end
      end
    end
  end

  bit tog_en = 0;
  always @(negedge clk) if (tog_en) host_ctrl <= host_ctrl + 3'd3;

  task automatic run_load();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e0;
    // R12 reset state
    repeat (3) @(negedge clk);
    chk(done == 0, "R12", "done", done, 0);
    chk(reg_we == 0, "R12", "reg_we", reg_we, 0);
    chk(ee_cs == 0 && ee_sk == 0, "R12", "cs/sk", {ee_cs, ee_sk}, 0);
    chk(phy_rst == 1, "R12", "phy_rst", phy_rst, 1);

    // A: active-low, pad entry, host bits toggling (R11)
    new_image();
    add_entry(8'h10, 16'hAAAA); add_entry(CMD, 16'h0000); add_entry(8'h12, 16'h1234);
    add_entry(8'h28, 16'h5555); add_entry(8'h14, 16'hBEEF);
    mem[wp] = 16'hFFFF;
    act_lvl = 1'b0; e0 = sb_err; tog_en = 1;
    run_load();
    tog_en = 0; host_ctrl = 3'b000;
    chk(sb_err == e0 && expq.size() == 0, "R11", "writes under host toggling", sb_err - e0, 0);
    chk(expq.size() == 0, "R2", "pending writes", expq.size(), 0);
    chk(pcnt == 4*SLOT, "R6", "pulse length", pcnt, 4*SLOT);
    chk(dcnt == 6*SLOT, "R6", "cycles to done", dcnt, 6*SLOT);
    chk(done == 1 && phy_rst == 1, "R9", "done/idle", {done, phy_rst}, 2'b11);
    chk(exp_ea == 11, "R2", "reads issued", exp_ea, 11);

    // B: active-high, two pad entries lengthen pulse
    new_image();
    add_entry(CMD, 16'h0001); add_entry(8'h20, 16'h0F0F); add_entry(8'h28, 16'h0000);
    add_entry(8'h28, 16'h0000); add_entry(8'h22, 16'h00FF);
    mem[wp] = 16'hFFFF;
    act_lvl = 1'b1;
    run_load();
    chk(expq.size() == 0, "R4", "pad entries skipped", expq.size(), 0);
    chk(pcnt == 5*SLOT, "R4", "pulse with pads", pcnt, 5*SLOT);
    chk(pcnt == 5*SLOT, "R5", "active-high level", pcnt, 5*SLOT);
    chk(done == 1 && phy_rst == 0, "R9", "idle after done", phy_rst, 0);

    // C: power-good window
    new_image();
    add_entry(CMD, 16'h0000); add_entry(8'h30, 16'h1111); add_entry(8'h31, 16'h2222);
    mem[wp] = 16'hFFFF;
    act_lvl = 1'b0;
    fork
      run_load();
      begin
        repeat (303) @(negedge clk);
        pg = 1'b0;
        repeat (300) @(negedge clk);
        pg = 1'b1;
      end
    join
    chk(pgbad == 0, "R7", "active while pg low", pgbad, 0);
    chk(pglow == 300, "R7", "pg low cycles seen", pglow, 300);
    chk(pcnt + pglow == 3*SLOT, "R6", "pulse incl gated", pcnt + pglow, 3*SLOT);
    chk(pcnt == 3*SLOT - 300, "R5", "active-low level count", pcnt, 3*SLOT - 300);

    // D: end marker only
    new_image();
    mem[0] = 16'hFFFF;
    run_load();
    chk(dcnt == SLOT, "R9", "done after one slot", dcnt, SLOT);
    chk(pcnt == 0 && phy_rst == 1, "R6", "no pulse", pcnt, 0);
    chk(exp_ea == 1, "R2", "single read", exp_ea, 1);

    // E: host bit-bang
    model_chk = 0;
    host_ctrl = 3'b110; @(negedge clk);
    chk({ee_cs, ee_sk, ee_di} == 3'b110, "R10", "pins 110", {ee_cs, ee_sk, ee_di}, 3'b110);
    host_ctrl = 3'b001; @(negedge clk);
    chk({ee_cs, ee_sk, ee_di} == 3'b001, "R10", "pins 001", {ee_cs, ee_sk, ee_di}, 3'b001);
    ovr_en = 1'b1; ovr_val = 1'b1; #1;
    chk(host_do == 1, "R10", "host_do 1", host_do, 1);
    ovr_val = 1'b0; #1;
    chk(host_do == 0, "R10", "host_do 0", host_do, 0);

    if (!wd_hit) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule